// File: doc/BRIEF.md
# DDR2 Command Timing Enforcer

This block sits between a DDR2 command scheduler and the memory interface. Each clock it sees at most one proposed command: an opcode and a bank index. It raises a grant in the same cycle only when every minimum spacing that applies since earlier granted commands has elapsed. A command that is not yet legal gets no grant, and the scheduler presents it again in a later cycle. Per-bank down-counters track the row-related spacings. Shared counters track refresh recovery, the activate-to-activate spacing across banks and the write-to-read turnaround.

All spacing limits come from one 32-bit timing word. Software can write the word only while a separate unlock input is high. Each field stores a cycle count minus one, so a field value N enforces a gap of N+1 cycles between the two grants. A write that changes the write-recovery field raises a one-cycle request to re-run the memory initialization sequence. A write that would make the active-to-precharge limit shorter than the activate-to-column limit is rejected and flagged.

Top module: `ddr2_cmd_timing_guard`

## Requirements
- R1: After reset the timing word reads 0x356B4B9B, and `init_req` and `cfg_err` are 0. Field layout: [31:25] refresh recovery, [24:22] precharge period, [21:19] activate-to-column, [18:16] write recovery, [15:11] active-to-precharge, [10:6] activate-to-activate same bank, [5:3] activate-to-activate any bank, [2] reserved, [1:0] write-to-read.
- R2: A write with `cfg_we`=1 takes effect at the clock edge only when `cfg_unlock`=1. With `cfg_unlock`=0 the word stays unchanged.
- R3: Bit 2 of the stored word always reads 0, whatever value was written to it.
- R4: An accepted write whose bits [18:16] differ from the stored value makes `init_req` high for exactly the one cycle after the write edge. An accepted write with the same bits [18:16] leaves `init_req` low.
- R5: An unlocked write whose bits [15:11] are less than its bits [21:19] is discarded and makes `cfg_err` high for the one cycle after the edge. It raises no `init_req`.
- R6: After a refresh or load-mode grant, the next refresh or activate grant comes at least tRFC+1 cycles later.
- R7: After a precharge grant to a bank, an activate to that bank, or any refresh, comes at least tRP+1 cycles later.
- R8: After an activate grant to a bank, a read or write to that bank comes at least tRCD+1 cycles later.
- R9: After a write grant to a bank, a precharge to that bank comes at least tWR+1 cycles later. A read to any bank comes at least tWTR+1 cycles after any write grant.
- R10: After an activate grant to a bank, a precharge to that bank comes at least tRAS+1 cycles later, and another activate to that bank at least tRC+1 cycles later.
- R11: Any activate comes at least tRRD+1 cycles after the previous activate grant, including one to a different bank.
- R12: `cmd_grant` is combinational in the cycle the command is presented, and it is 0 whenever `cmd_valid` is 0. Opcodes: 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 load mode. Opcodes 0 and 7 are never granted. Load mode is always granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_unlock | input | 1 | Write enable gate for the timing word |
| cfg_wdata | input | 32 | Timing word write data |
| cfg_rdata | output | 32 | Stored timing word |
| init_req | output | 1 | One-cycle initialization request pulse |
| cfg_err | output | 1 | One-cycle pulse for a rejected write |
| cmd_valid | input | 1 | A command is proposed this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_bank | input | BANK_W | Target bank |
| cmd_grant | output | 1 | Command is legal and issued this cycle |

## Verification
The grant is due in the same cycle as the command it answers. The bench therefore sets up the command after a falling edge and samples `cmd_grant` one time unit later, before the next rising edge. Each spacing is measured as the number of cycles from the first grant to the first cycle in which a continuously presented second command is granted, and this count must equal the field value plus one. The configuration results `cfg_rdata`, `init_req` and `cfg_err` are registered, so the bench reads them in the cycle after the write edge. It reads `init_req` and `cfg_err` once more a cycle later to confirm that each pulse lasts exactly one cycle.

// File: rtl/ddr2_tg_pkg.sv
package ddr2_tg_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_REF  = 3'd5,
        OP_LMR  = 3'd6,
        OP_RSV  = 3'd7
    } cmd_op_e;

    // Packed layout of the timing word, MSB first.
    typedef struct packed {
        logic [6:0] rfc;
        logic [2:0] rp;
        logic [2:0] rcd;
        logic [2:0] wr;
        logic [4:0] ras;
        logic [4:0] rc;
        logic [2:0] rrd;
        logic       rsv;
        logic [1:0] wtr;
    } timing_t;

    localparam logic [31:0] TIMING_RST = 32'h356B_4B9B;
    localparam int CNT_W  = 5;
    localparam int RFC_W  = 7;

    function automatic logic [CNT_W-1:0] dec_cnt(input logic [CNT_W-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    function automatic logic [RFC_W-1:0] dec_rfc(input logic [RFC_W-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

endpackage

// File: rtl/ddr2_tg_cfg.sv
module ddr2_tg_cfg
    import ddr2_tg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        unlock,
    input  logic [31:0] wdata,
    output timing_t     word,
    output logic        init_pulse,
    output logic        err_pulse
);

    typedef struct packed {
        timing_t word;
        logic    init;
        logic    err;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    timing_t nw;

    always_comb begin
        st_d      = st_q;
        st_d.init = 1'b0;
        st_d.err  = 1'b0;
        nw        = timing_t'(wdata);
        nw.rsv    = 1'b0;
        if (wr_en && unlock) begin
            if (nw.ras < {2'b00, nw.rcd}) begin
                st_d.err = 1'b1;
            end else begin
                st_d.word = nw;
                st_d.init = (nw.wr != st_q.word.wr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word <= timing_t'(TIMING_RST);
            st_q.init <= 1'b0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word       = st_q.word;
    assign init_pulse = st_q.init;
    assign err_pulse  = st_q.err;

endmodule

// File: rtl/ddr2_tg_bank.sv
module ddr2_tg_bank
    import ddr2_tg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_go,
    input  logic       wr_go,
    input  logic       pre_go,
    input  logic [2:0] t_rcd,
    input  logic [2:0] t_rp,
    input  logic [2:0] t_wr,
    input  logic [4:0] t_ras,
    input  logic [4:0] t_rc,
    output logic       act_ok,
    output logic       rw_ok,
    output logic       pre_ok,
    output logic       rp_done
);

    typedef struct packed {
        logic [CNT_W-1:0] rcd;
        logic [CNT_W-1:0] rp;
        logic [CNT_W-1:0] wr;
        logic [CNT_W-1:0] ras;
        logic [CNT_W-1:0] rc;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d.rcd = dec_cnt(st_q.rcd);
        st_d.rp  = dec_cnt(st_q.rp);
        st_d.wr  = dec_cnt(st_q.wr);
        st_d.ras = dec_cnt(st_q.ras);
        st_d.rc  = dec_cnt(st_q.rc);
        if (act_go) begin
            st_d.rcd = {2'b00, t_rcd};
            st_d.ras = t_ras;
            st_d.rc  = t_rc;
        end
        if (pre_go) st_d.rp = {2'b00, t_rp};
        if (wr_go)  st_d.wr = {2'b00, t_wr};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_ok  = (st_q.rc == '0) && (st_q.rp == '0);
    assign rw_ok   = (st_q.rcd == '0);
    assign pre_ok  = (st_q.ras == '0) && (st_q.wr == '0);
    assign rp_done = (st_q.rp == '0);

endmodule

// File: rtl/ddr2_cmd_timing_guard.sv
module ddr2_cmd_timing_guard
    import ddr2_tg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_unlock,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              init_req,
    output logic              cfg_err,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    output logic              cmd_grant
);

    typedef struct packed {
        logic [RFC_W-1:0] rfc;
        logic [CNT_W-1:0] rrd;
        logic [CNT_W-1:0] wtr;
    } glb_st_t;

    timing_t            tw;
    glb_st_t            g_d, g_q;
    cmd_op_e            op;
    logic               legal;
    logic [NUM_BANKS-1:0] act_ok, rw_ok, pre_ok, rp_done;
    logic [NUM_BANKS-1:0] act_go, wr_go, pre_go;

    ddr2_tg_cfg cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .unlock     (cfg_unlock),
        .wdata      (cfg_wdata),
        .word       (tw),
        .init_pulse (init_req),
        .err_pulse  (cfg_err)
    );

    assign cfg_rdata = tw;
    assign op        = cmd_op_e'(cmd_op);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign act_go[b] = cmd_grant && (op == OP_ACT) && (cmd_bank == BANK_W'(b));
        assign wr_go[b]  = cmd_grant && (op == OP_WR)  && (cmd_bank == BANK_W'(b));
        assign pre_go[b] = cmd_grant && (op == OP_PRE) && (cmd_bank == BANK_W'(b));

        ddr2_tg_bank bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_go  (act_go[b]),
            .wr_go   (wr_go[b]),
            .pre_go  (pre_go[b]),
            .t_rcd   (tw.rcd),
            .t_rp    (tw.rp),
            .t_wr    (tw.wr),
            .t_ras   (tw.ras),
            .t_rc    (tw.rc),
            .act_ok  (act_ok[b]),
            .rw_ok   (rw_ok[b]),
            .pre_ok  (pre_ok[b]),
            .rp_done (rp_done[b])
        );
    end

    always_comb begin
        unique case (op)
            OP_ACT:  legal = (g_q.rfc == '0) && (g_q.rrd == '0) && act_ok[cmd_bank];
            OP_RD:   legal = rw_ok[cmd_bank] && (g_q.wtr == '0);
            OP_WR:   legal = rw_ok[cmd_bank];
            OP_PRE:  legal = pre_ok[cmd_bank];
            OP_REF:  legal = (g_q.rfc == '0) && (&rp_done);
            OP_LMR:  legal = 1'b1;
            default: legal = 1'b0;
        endcase
    end

    assign cmd_grant = cmd_valid && legal;

    always_comb begin
        g_d.rfc = dec_rfc(g_q.rfc);
        g_d.rrd = dec_cnt(g_q.rrd);
        g_d.wtr = dec_cnt(g_q.wtr);
        if (cmd_grant) begin
            if (op == OP_REF || op == OP_LMR) g_d.rfc = tw.rfc;
            if (op == OP_ACT)                 g_d.rrd = {2'b00, tw.rrd};
            if (op == OP_WR)                  g_d.wtr = {3'b000, tw.wtr};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

endmodule

// File: rtl/ddr2_tg_checker.sv
module ddr2_tg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic        cfg_unlock,
    input logic [31:0] cfg_rdata,
    input logic        init_req,
    input logic        cfg_err,
    input logic        cmd_valid,
    input logic [2:0]  cmd_op,
    input logic        cmd_grant
);

    assert_locked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_unlock) |=> $stable(cfg_rdata));

    assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[2] == 1'b0);

    assert_init_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> !init_req);

    assert_err_no_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !init_req);

    assert_rfc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_grant && cmd_op == 3'd5 && cfg_rdata[31:25] != 7'd0 && !cfg_we)
        |=> !(cmd_grant && (cmd_op == 3'd5 || cmd_op == 3'd1)));

    assert_rrd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_grant && cmd_op == 3'd1 && cfg_rdata[5:3] != 3'd0 && !cfg_we)
        |=> !(cmd_grant && cmd_op == 3'd1));

    assert_grant_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_grant |-> (cmd_valid && cmd_op != 3'd0 && cmd_op != 3'd7));

endmodule

bind ddr2_cmd_timing_guard ddr2_tg_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_unlock (cfg_unlock),
    .cfg_rdata  (cfg_rdata),
    .init_req   (init_req),
    .cfg_err    (cfg_err),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_grant  (cmd_grant)
);

// File: tb/ddr2_cmd_timing_guard_tb_top.sv
module ddr2_cmd_timing_guard_tb_top;

    localparam int NB = 8;
    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_unlock = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          init_req;
    logic          cfg_err;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [BW-1:0] cmd_bank = '0;
    logic          cmd_grant;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ddr2_cmd_timing_guard #(.NUM_BANKS(NB)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_unlock (cfg_unlock),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .init_req   (init_req),
        .cfg_err    (cfg_err),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_bank   (cmd_bank),
        .cmd_grant  (cmd_grant)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        cmd_valid = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Grant-to-grant spacing of a second command presented every cycle.
    task automatic gap_test(input string req, input logic [2:0] op1, input logic [BW-1:0] b1,
                            input logic [2:0] op2, input logic [BW-1:0] b2, input int exp);
        int k;
        idle(140);
        cmd_valid = 1'b1; cmd_op = op1; cmd_bank = b1;
        #1;
        chk(req, "first command grant", 32'(cmd_grant), 32'd1);
        @(negedge clk);
        cmd_op = op2; cmd_bank = b2;
        k = 1;
        #1;
        while (!cmd_grant && k < 200) begin
            @(negedge clk);
            k++;
            #1;
        end
        chk(req, "grant spacing", 32'(k), 32'(exp));
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Write the word; look at registered outputs one and two cycles on.
    task automatic cfg_write(input string req, input logic unl, input logic [31:0] data,
                             input logic [31:0] exp_word, input logic exp_init, input logic exp_err);
        @(negedge clk);
        cfg_we = 1'b1; cfg_unlock = unl; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_unlock = 1'b0;
        #1;
        chk(req, "word after write", cfg_rdata, exp_word);
        chk(req, "init_req pulse", 32'(init_req), 32'(exp_init));
        chk(req, "cfg_err pulse", 32'(cfg_err), 32'(exp_err));
        @(negedge clk);
        #1;
        chk(req, "init_req one cycle", 32'(init_req), 32'd0);
        chk(req, "cfg_err one cycle", 32'(cfg_err), 32'd0);
    endtask

    task automatic test_reset();
        #1;
        chk("R1", "reset word", cfg_rdata, 32'h356B_4B9B);
        chk("R1", "reset init_req", 32'(init_req), 32'd0);
        chk("R1", "reset cfg_err", 32'(cfg_err), 32'd0);
    endtask

    task automatic test_default_gaps();
        gap_test("R6",  3'd5, 3'd0, 3'd1, 3'd2, 27);
        gap_test("R6",  3'd6, 3'd0, 3'd5, 3'd0, 27);
        gap_test("R7",  3'd4, 3'd3, 3'd1, 3'd3, 6);
        gap_test("R7",  3'd4, 3'd3, 3'd5, 3'd0, 6);
        gap_test("R8",  3'd1, 3'd4, 3'd2, 3'd4, 6);
        gap_test("R9",  3'd3, 3'd5, 3'd4, 3'd5, 4);
        gap_test("R9",  3'd3, 3'd5, 3'd2, 3'd1, 4);
        gap_test("R10", 3'd1, 3'd6, 3'd4, 3'd6, 10);
        gap_test("R10", 3'd1, 3'd6, 3'd1, 3'd6, 15);
        gap_test("R11", 3'd1, 3'd0, 3'd1, 3'd7, 4);
    endtask

    task automatic test_grant_rules();
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd6;
        #1 chk("R12", "no grant without valid", 32'(cmd_grant), 32'd0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0;
        #1 chk("R12", "opcode 0 not granted", 32'(cmd_grant), 32'd0);
        @(negedge clk);
        cmd_op = 3'd7;
        #1 chk("R12", "opcode 7 not granted", 32'(cmd_grant), 32'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
        gap_test("R12", 3'd6, 3'd0, 3'd6, 3'd0, 1);
    endtask

    task automatic test_config();
        cfg_write("R2", 1'b0, 32'h0000_0000, 32'h356B_4B9B, 1'b0, 1'b0);
        // rfc=3 rp=2 rcd=1 wr=5 ras=4 rc=6 rrd=0 rsv=1 wtr=1
        cfg_write("R4", 1'b1, 32'h068D_2185, 32'h068D_2181, 1'b1, 1'b0);
        chk("R3", "reserved bit reads 0", 32'(cfg_rdata[2]), 32'd0);
        gap_test("R6",  3'd5, 3'd0, 3'd5, 3'd0, 4);
        gap_test("R7",  3'd4, 3'd2, 3'd1, 3'd2, 3);
        gap_test("R8",  3'd1, 3'd1, 3'd3, 3'd1, 2);
        gap_test("R9",  3'd3, 3'd1, 3'd4, 3'd1, 6);
        gap_test("R10", 3'd1, 3'd2, 3'd1, 3'd2, 7);
        gap_test("R11", 3'd1, 3'd2, 3'd1, 3'd3, 1);
        cfg_write("R4", 1'b1, 32'h088D_2181, 32'h088D_2181, 1'b0, 1'b0);
        cfg_write("R5", 1'b1, 32'h356B_139B, 32'h088D_2181, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_default_gaps();
        test_grant_rules();
        test_config();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule